// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between the command issuer of an SDRAM controller and the memory pins. It keeps the open or closed state of every bank. It also keeps the time that has passed since each timing-relevant event. With this it decides, in the same cycle, whether the command that is presented may legally go out. The issuer presents a command code and a bank address. It reads `cmd_allowed` combinationally and raises `cmd_valid` only when it actually drives the command to the pins.

The guard tracks every command that is issued, including one that breaks a rule. An illegal command sets a sticky violation flag and latches a cause code. The flag and code stay until a synchronous clear. A bank that stays open past the maximum row-active time is also reported as a violation.

The clock period and the nanosecond limits are elaboration parameters, given in picoseconds. Each limit becomes a whole number of clocks. The limits counted in clocks are given as clock counts directly. The write burst length sets where the last write data beat falls.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, PRECHARGE-ALL=5, BURST STOP=6. Code 7 behaves as NOP. NOP is always allowed, changes no state and never raises a violation.
- R2: Each picosecond limit becomes a clock count equal to limit divided by clock period, rounded up. The defaults at a 10 ns clock give: row cycle 7, row-active minimum 5, precharge period 3, activate-to-access 3, activate-to-activate on another bank 2.
- R3: ACTIVE to a bank is allowed only if all of these hold: the bank is closed; at least the row-cycle count of clocks has passed since that bank's last ACTIVE; at least the precharge-period count has passed since that bank's last precharge.
- R4: ACTIVE is allowed only if at least the activate-to-activate count of clocks has passed since the last ACTIVE to any bank.
- R5: READ or WRITE is allowed only to an open bank, and only at least the activate-to-access count of clocks after that bank's ACTIVE.
- R6: A READ or WRITE is allowed at least the access-to-access clock count after the previous READ or WRITE to any bank. With the default of 1, back-to-back accesses are allowed.
- R7: PRECHARGE to an open bank is allowed only when both of these hold: at least the row-active minimum has passed since its ACTIVE; at least the data-to-precharge clock count has passed since the last write data beat to that bank. The last write data beat is the WRITE cycle plus burst length minus one. PRECHARGE to a closed bank is always allowed. Every precharge closes the bank and restarts its precharge-period window.
- R8: PRECHARGE-ALL is allowed only when the R7 conditions hold for every open bank. It closes all banks and restarts the precharge-period window on every bank.
- R9: BURST STOP is allowed only at least the data-to-burst-stop clock count after the last write data beat.
- R10: A bank whose open time reaches the row-active maximum count, with no precharge to it in that cycle, raises a violation with cause 11 at the next edge. The violation is raised once per opening. A precharge in exactly that cycle is legal.
- R11: A command with `cmd_valid` high and `cmd_allowed` low sets `viol_sticky` at the next edge and latches a cause. The causes are: 1 ACTIVE to an open bank, 2 row cycle, 3 precharge period, 4 activate-to-activate, 5 access to a closed bank, 6 activate-to-access, 7 access-to-access, 8 row-active minimum, 9 data-to-precharge, 10 data-to-burst-stop. The lowest failing code is chosen. A command cause wins over cause 11. While the flag is set, the cause holds.
- R12: After reset, all banks are closed, every window has expired, and the flag and cause are 0. `viol_clear` clears the flag and cause at the next edge. If a new violation occurs in the same cycle as a clear, the new violation is latched instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Presented command is driven to the memory this cycle |
| cmd_code | input | 3 | Command code (R1 encoding) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| viol_clear | input | 1 | Synchronous clear of the violation flag and cause |
| cmd_allowed | output | 1 | Presented command meets every timing rule this cycle |
| viol_sticky | output | 1 | Sticky violation flag |
| viol_cause | output | 4 | Cause of the first latched violation |

## Verification
`cmd_allowed` is combinational, so the bench drives each command on the falling edge. It reads the verdict 1 ns later, in the same cycle and before any edge can change the state. Window boundaries are probed this way with `cmd_valid` low, which leaves the state untouched. The flag and cause register at the edge that ends the offending cycle, and the bench reads them at the following falling edge. The row-active maximum flag appears one edge after the cycle in which the open time reaches the limit. The bench checks the flag as clear in that cycle and as set one cycle later.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_PALL = 3'd5,
      CMD_BST  = 3'd6,
      CMD_RSVD = 3'd7
   } cmd_e;

   typedef enum logic [3:0] {
      CAUSE_NONE     = 4'd0,
      CAUSE_ACT_OPEN = 4'd1,
      CAUSE_RC       = 4'd2,
      CAUSE_RP       = 4'd3,
      CAUSE_RRD      = 4'd4,
      CAUSE_CLOSED   = 4'd5,
      CAUSE_RCD      = 4'd6,
      CAUSE_CCD      = 4'd7,
      CAUSE_RAS_MIN  = 4'd8,
      CAUSE_DPL      = 4'd9,
      CAUSE_BDL      = 4'd10,
      CAUSE_RAS_MAX  = 4'd11
   } cause_e;

   // limit in ps to clocks, any fraction counts as a whole clock
   function automatic int unsigned ps_to_cycles(input longint unsigned lim_ps,
                                                input longint unsigned per_ps);
      return 32'((lim_ps + per_ps - 64'd1) / per_ps);
   endfunction

endpackage

// File: rtl/guard_downcnt.sv
module guard_downcnt #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_CNT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val)); // R2
   AST_CNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> cnt_q <= $past(cnt_q)); // R2

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
   parameter int unsigned RC_CK      = 7,
   parameter int unsigned RP_CK      = 3,
   parameter int unsigned RCD_CK     = 3,
   parameter int unsigned RAS_CK     = 5,
   parameter int unsigned RAS_MAX_CK = 12000,
   parameter int unsigned DPL_LD     = 1,
   parameter int unsigned CW         = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic wr_i,
   input  logic pre_i,
   output logic open_o,
   output logic rc_ok_o,
   output logic rp_ok_o,
   output logic rcd_ok_o,
   output logic ras_ok_o,
   output logic dpl_ok_o,
   output logic ras_over_o
);

   localparam int unsigned AW = $clog2(RAS_MAX_CK + 2);

   logic          open_q;
   logic [AW-1:0] age_q;

   guard_downcnt #(.W(CW)) u_rc (
      .clk(clk), .rst_n(rst_n), .load(act_i),
      .load_val(CW'(RC_CK - 1)), .expired(rc_ok_o));

   guard_downcnt #(.W(CW)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(pre_i),
      .load_val(CW'(RP_CK - 1)), .expired(rp_ok_o));

   guard_downcnt #(.W(CW)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(act_i),
      .load_val(CW'(RCD_CK - 1)), .expired(rcd_ok_o));

   guard_downcnt #(.W(CW)) u_dpl (
      .clk(clk), .rst_n(rst_n), .load(wr_i),
      .load_val(CW'(DPL_LD)), .expired(dpl_ok_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          open_q <= 1'b0;
      else if (act_i)      open_q <= 1'b1;
      else if (pre_i)      open_q <= 1'b0;
   end

   // open age: k clocks after ACTIVE reads k, saturates one past the maximum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        age_q <= '0;
      else if (act_i)                                    age_q <= AW'(1);
      else if (open_q && age_q != AW'(RAS_MAX_CK + 1))   age_q <= age_q + 1'b1;
   end

   assign open_o     = open_q;
   assign ras_ok_o   = (age_q >= AW'(RAS_CK));
   assign ras_over_o = open_q && (age_q == AW'(RAS_MAX_CK)) && !pre_i && !act_i;

   AST_BANK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |=> open_o); // R3
   AST_BANK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_i && !act_i) |=> !open_o); // R7
   AST_RAS_MAX_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ras_over_o |=> !ras_over_o); // R10

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
   import sdram_guard_pkg::*;
#(
   parameter int unsigned NUM_BANKS     = 4,
   parameter int unsigned CLK_PERIOD_PS = 10000,
   parameter int unsigned T_RC_PS       = 67500,
   parameter int unsigned T_RAS_PS      = 45000,
   parameter int unsigned T_RAS_MAX_PS  = 120000000,
   parameter int unsigned T_RP_PS       = 22500,
   parameter int unsigned T_RCD_PS      = 22500,
   parameter int unsigned T_RRD_PS      = 15000,
   parameter int unsigned T_CCD_CK      = 1,
   parameter int unsigned T_DPL_CK      = 2,
   parameter int unsigned T_BDL_CK      = 1,
   parameter int unsigned WR_BURST_LEN  = 1,
   localparam int unsigned BANK_W       = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_code,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              viol_clear,
   output logic              cmd_allowed,
   output logic              viol_sticky,
   output logic [3:0]        viol_cause
);

   localparam int unsigned RC_CK      = ps_to_cycles(T_RC_PS, CLK_PERIOD_PS);
   localparam int unsigned RAS_CK     = ps_to_cycles(T_RAS_PS, CLK_PERIOD_PS);
   localparam int unsigned RAS_MAX_CK = ps_to_cycles(T_RAS_MAX_PS, CLK_PERIOD_PS);
   localparam int unsigned RP_CK      = ps_to_cycles(T_RP_PS, CLK_PERIOD_PS);
   localparam int unsigned RCD_CK     = ps_to_cycles(T_RCD_PS, CLK_PERIOD_PS);
   localparam int unsigned RRD_CK     = ps_to_cycles(T_RRD_PS, CLK_PERIOD_PS);
   localparam int unsigned DPL_LD     = WR_BURST_LEN - 1 + T_DPL_CK - 1;
   localparam int unsigned BDL_LD     = WR_BURST_LEN - 1 + T_BDL_CK - 1;
   localparam int unsigned CW = $clog2(RC_CK + RP_CK + RCD_CK + RRD_CK + T_CCD_CK
                                       + DPL_LD + BDL_LD + 2);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (CLK_PERIOD_PS == 0 || T_RC_PS == 0 || T_RAS_PS == 0 || T_RP_PS == 0
       || T_RCD_PS == 0 || T_RRD_PS == 0) begin : g_bad_limits
      $error("clock period and every limit must be non-zero");
   end
   if (T_CCD_CK == 0 || T_DPL_CK == 0 || T_BDL_CK == 0 || WR_BURST_LEN == 0) begin : g_bad_clk_counts
      $error("clock-count limits and burst length must be at least 1");
   end
   if (RAS_MAX_CK <= RAS_CK) begin : g_bad_ras
      $error("row-active maximum must exceed the row-active minimum");
   end

   cmd_e                 code;
   logic                 is_act, is_rd, is_wr, is_pre, is_pall, is_bst;
   logic [NUM_BANKS-1:0] act_v, wr_v, pre_v;
   logic [NUM_BANKS-1:0] open_v, rc_ok_v, rp_ok_v, rcd_ok_v, ras_ok_v, dpl_ok_v, over_v;
   logic                 rrd_ok, ccd_ok, bdl_ok;
   logic                 pall_ras_ok, pall_dpl_ok;
   cause_e               cause_now, event_cause;
   logic                 sticky_q;
   cause_e               cause_q;

   assign code    = cmd_e'(cmd_code);
   assign is_act  = (code == CMD_ACT);
   assign is_rd   = (code == CMD_RD);
   assign is_wr   = (code == CMD_WR);
   assign is_pre  = (code == CMD_PRE);
   assign is_pall = (code == CMD_PALL);
   assign is_bst  = (code == CMD_BST);

   // per-bank trackers
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit      = cmd_valid && (cmd_bank == BANK_W'(b));
      assign act_v[b] = hit && is_act;
      assign wr_v[b]  = hit && is_wr;
      assign pre_v[b] = (hit && is_pre) || (cmd_valid && is_pall);

      sdram_bank_tracker #(
         .RC_CK(RC_CK), .RP_CK(RP_CK), .RCD_CK(RCD_CK), .RAS_CK(RAS_CK),
         .RAS_MAX_CK(RAS_MAX_CK), .DPL_LD(DPL_LD), .CW(CW)
      ) u_trk (
         .clk(clk), .rst_n(rst_n),
         .act_i(act_v[b]), .wr_i(wr_v[b]), .pre_i(pre_v[b]),
         .open_o(open_v[b]), .rc_ok_o(rc_ok_v[b]), .rp_ok_o(rp_ok_v[b]),
         .rcd_ok_o(rcd_ok_v[b]), .ras_ok_o(ras_ok_v[b]), .dpl_ok_o(dpl_ok_v[b]),
         .ras_over_o(over_v[b]));
   end

   // device-wide windows
   guard_downcnt #(.W(CW)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(cmd_valid && is_act),
      .load_val(CW'(RRD_CK - 1)), .expired(rrd_ok));

   if (T_CCD_CK > 1) begin : g_ccd_cnt
      guard_downcnt #(.W(CW)) u_ccd (
         .clk(clk), .rst_n(rst_n), .load(cmd_valid && (is_rd || is_wr)),
         .load_val(CW'(T_CCD_CK - 1)), .expired(ccd_ok));
   end else begin : g_ccd_none
      assign ccd_ok = 1'b1;
   end

   if (BDL_LD > 0) begin : g_bdl_cnt
      guard_downcnt #(.W(CW)) u_bdl (
         .clk(clk), .rst_n(rst_n), .load(cmd_valid && is_wr),
         .load_val(CW'(BDL_LD)), .expired(bdl_ok));
   end else begin : g_bdl_none
      assign bdl_ok = 1'b1;
   end

   assign pall_ras_ok = &(~open_v | ras_ok_v);
   assign pall_dpl_ok = &(~open_v | dpl_ok_v);

   // rule check for the presented command, lowest failing cause first
   always_comb begin
      cause_now = CAUSE_NONE;
      unique case (code)
         CMD_ACT: begin
            if (open_v[cmd_bank])         cause_now = CAUSE_ACT_OPEN;
            else if (!rc_ok_v[cmd_bank])  cause_now = CAUSE_RC;
            else if (!rp_ok_v[cmd_bank])  cause_now = CAUSE_RP;
            else if (!rrd_ok)             cause_now = CAUSE_RRD;
         end
         CMD_RD, CMD_WR: begin
            if (!open_v[cmd_bank])        cause_now = CAUSE_CLOSED;
            else if (!rcd_ok_v[cmd_bank]) cause_now = CAUSE_RCD;
            else if (!ccd_ok)             cause_now = CAUSE_CCD;
         end
         CMD_PRE: begin
            if (open_v[cmd_bank] && !ras_ok_v[cmd_bank])      cause_now = CAUSE_RAS_MIN;
            else if (open_v[cmd_bank] && !dpl_ok_v[cmd_bank]) cause_now = CAUSE_DPL;
         end
         CMD_PALL: begin
            if (!pall_ras_ok)             cause_now = CAUSE_RAS_MIN;
            else if (!pall_dpl_ok)        cause_now = CAUSE_DPL;
         end
         CMD_BST: begin
            if (!bdl_ok)                  cause_now = CAUSE_BDL;
         end
         default: cause_now = CAUSE_NONE;
      endcase
   end

   assign cmd_allowed = (cause_now == CAUSE_NONE);

   always_comb begin
      if (cmd_valid && cause_now != CAUSE_NONE) event_cause = cause_now;
      else if (|over_v)                         event_cause = CAUSE_RAS_MAX;
      else                                      event_cause = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         cause_q  <= CAUSE_NONE;
      end else if (event_cause != CAUSE_NONE && (!sticky_q || viol_clear)) begin
         sticky_q <= 1'b1;
         cause_q  <= event_cause;
      end else if (viol_clear) begin
         sticky_q <= 1'b0;
         cause_q  <= CAUSE_NONE;
      end
   end

   assign viol_sticky = sticky_q;
   assign viol_cause  = cause_q;

   AST_ILLEGAL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_allowed) |=> viol_sticky); // R11
   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_sticky && !viol_clear) |=> viol_sticky && $stable(viol_cause)); // R11
   AST_CAUSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky |-> viol_cause != 4'd0); // R11
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_clear && !(cmd_valid && !cmd_allowed) && over_v == '0) |=> !viol_sticky); // R12

endmodule

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb;

   localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                          PRE = 3'd4, PALL = 3'd5, BST = 3'd6, RSVD = 3'd7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_code = NOP;
   logic [1:0] cmd_bank = 2'd0;
   logic       viol_clear = 1'b0;
   logic       cmd_allowed, viol_sticky;
   logic [3:0] viol_cause;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sdram_cmd_guard #(
      .T_RAS_MAX_PS(300000),
      .WR_BURST_LEN(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_bank(cmd_bank), .viol_clear(viol_clear), .cmd_allowed(cmd_allowed),
      .viol_sticky(viol_sticky), .viol_cause(viol_cause));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_pulse();
      viol_clear = 1'b1;
      @(negedge clk);
      viol_clear = 1'b0;
   endtask

   // probe verdict without issuing
   task automatic query(input logic [2:0] c, input logic [1:0] b, input bit exp, input string req);
      cmd_valid = 1'b0; cmd_code = c; cmd_bank = b;
      #1;
      chk(cmd_allowed == exp, req, $sformatf("allowed code %0d bank %0d", c, b), cmd_allowed, exp);
   endtask

   // issue for one cycle, checking the verdict in that cycle
   task automatic issue(input logic [2:0] c, input logic [1:0] b, input bit exp,
                        input string req, input bit clr = 1'b0);
      cmd_valid = 1'b1; cmd_code = c; cmd_bank = b; viol_clear = clr;
      #1;
      chk(cmd_allowed == exp, req, $sformatf("issued code %0d bank %0d", c, b), cmd_allowed, exp);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = NOP; viol_clear = 1'b0;
   endtask

   task automatic flags(input bit exp_s, input int exp_c, input string req);
      #1;
      chk(viol_sticky == exp_s, req, "viol_sticky", viol_sticky, exp_s);
      chk(viol_cause == 4'(exp_c), req, "viol_cause", viol_cause, exp_c);
   endtask

   task automatic t_reset();
      flags(1'b0, 0, "R12");
      query(RD, 2'd0, 1'b0, "R12");
      query(ACT, 2'd0, 1'b1, "R12");
      query(PALL, 2'd0, 1'b1, "R12");
   endtask

   task automatic t_activate();
      issue(ACT, 2'd0, 1'b1, "R3");                       // t
      query(RD, 2'd0, 1'b0, "R5");                        // t+1
      query(ACT, 2'd1, 1'b0, "R4");
      query(ACT, 2'd0, 1'b0, "R3");
      issue(NOP, 2'd0, 1'b1, "R1");                       // valid NOP at t+1
      query(ACT, 2'd1, 1'b1, "R4");                       // t+2: 2 clocks
      query(RD, 2'd0, 1'b0, "R2");
      issue(RSVD, 2'd3, 1'b1, "R1");                      // t+2
      issue(RD, 2'd0, 1'b1, "R5");                        // t+3: 3 clocks
      query(RD, 2'd0, 1'b1, "R6");                        // t+4
      query(PRE, 2'd0, 1'b0, "R7");
      idle(1);
      issue(PRE, 2'd0, 1'b1, "R2");                       // t+5: 45 ns -> 5
      query(ACT, 2'd0, 1'b0, "R3");                       // t+6
      idle(1);
      query(ACT, 2'd0, 1'b0, "R3");                       // t+7: tRC met, tRP not
      idle(1);
      query(ACT, 2'd0, 1'b1, "R3");                       // t+8
      flags(1'b0, 0, "R1");
   endtask

   task automatic t_write();
      issue(ACT, 2'd2, 1'b1, "R5");                       // t
      idle(2);
      issue(WR, 2'd2, 1'b1, "R5");                        // t+3, last beat t+4
      query(BST, 2'd0, 1'b0, "R9");                       // t+4
      query(PRE, 2'd2, 1'b0, "R7");
      idle(1);
      query(BST, 2'd0, 1'b1, "R9");                       // t+5
      query(PRE, 2'd2, 1'b0, "R7");
      query(PRE, 2'd1, 1'b1, "R7");                       // closed bank
      idle(1);
      issue(PRE, 2'd2, 1'b1, "R7");                       // t+6
      flags(1'b0, 0, "R7");
   endtask

   task automatic t_pall();
      issue(ACT, 2'd0, 1'b1, "R8");                       // t
      idle(1);
      issue(ACT, 2'd1, 1'b1, "R4");                       // t+2
      idle(2);
      query(PALL, 2'd0, 1'b0, "R8");                      // t+5
      idle(1);
      query(PALL, 2'd0, 1'b0, "R8");                      // t+6
      idle(1);
      issue(PALL, 2'd0, 1'b1, "R8");                      // t+7
      query(ACT, 2'd3, 1'b0, "R8");                       // t+8
      query(RD, 2'd1, 1'b0, "R8");
      idle(1);
      query(ACT, 2'd3, 1'b0, "R8");                       // t+9
      idle(1);
      query(ACT, 2'd3, 1'b1, "R8");                       // t+10
      flags(1'b0, 0, "R8");
   endtask

   task automatic t_violations();
      issue(RD, 2'd0, 1'b0, "R11");
      flags(1'b1, 5, "R11");
      issue(ACT, 2'd0, 1'b1, "R11");
      flags(1'b1, 5, "R11");
      issue(ACT, 2'd1, 1'b0, "R4");                       // tRRD fails, cause held
      flags(1'b1, 5, "R11");
      clear_pulse();
      flags(1'b0, 0, "R12");
      issue(RD, 2'd3, 1'b0, "R12", 1'b1);                 // clear and new violation
      flags(1'b1, 5, "R12");
      clear_pulse();
      flags(1'b0, 0, "R12");
      issue(ACT, 2'd0, 1'b0, "R11");                      // open bank beats tRC
      flags(1'b1, 1, "R11");
      clear_pulse();
      idle(10);
      issue(PALL, 2'd0, 1'b1, "R8");
      flags(1'b0, 0, "R12");
   endtask

   task automatic t_ras_max();
      issue(ACT, 2'd2, 1'b1, "R10");                      // t
      idle(29);
      issue(PRE, 2'd2, 1'b1, "R10");                      // t+30, exactly at limit
      flags(1'b0, 0, "R10");
      idle(5);
      issue(ACT, 2'd2, 1'b1, "R10");                      // u
      idle(29);
      flags(1'b0, 0, "R10");                              // u+30
      idle(1);
      flags(1'b1, 11, "R10");                             // u+31
      clear_pulse();
      flags(1'b0, 0, "R10");
      idle(3);
      flags(1'b0, 0, "R10");                              // no second report
      issue(PRE, 2'd2, 1'b1, "R7");
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_activate();
      idle(10);
      t_write();
      idle(10);
      t_pall();
      idle(10);
      t_violations();
      idle(10);
      t_ras_max();
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule